// File: doc/BRIEF.md
# Eight-Bit Mux-Programmed Arithmetic and Logic Unit

This block is a purely combinational eight-bit arithmetic and logic unit. It takes two operands, a carry input and a four-bit operation code, and returns an eight-bit result and a carry-out. An internal decoder turns the operation code into the controls for two paths, which both see the same operands.

The arithmetic path is a ripple-carry adder. Its second operand is chosen from the B operand, the bitwise inverse of B, or a fixed constant. The constant is one for increment and all-ones for decrement. The adder's carry-in is zero, one, or the external carry. The logic path treats a 4-to-1 multiplexer per bit as a programmable truth table. The operand bits drive the select lines, and a four-bit function code from the decoder drives the data inputs.

Operation-code bit 3 chooses which path drives the result. In the arithmetic group, bit 2 picks the constant over the B path, bit 1 picks the constant value or the inverted B, and bit 0 picks the external carry. The design has no clock and no state. The decoder's enumerated controls play the part of the state encoding: the operand mode is one of pass, invert or constant, and the carry mode is one of zero, one or external.

Top module: `alu8_mux_core`

## Requirements
- R1: Opcode 0000 gives {carry_out, result} = A + B, and opcode 0001 gives A + B + carry_in, as a 9-bit sum.
- R2: Opcode 0010 gives result = A − B modulo 256, with carry_out = 1 exactly when A ≥ B, which means no borrow.
- R3: Opcode 0011 gives {carry_out, result} = A + ~B + carry_in, where carry_in = 1 means no incoming borrow.
- R4: Opcode 0100 gives {carry_out, result} = A + 1, so carry_out = 1 only for A = 0xFF.
- R5: Opcode 0110 gives {carry_out, result} = A + 0xFF, so result = A − 1 modulo 256 and carry_out = 0 only for A = 0x00.
- R6: For each bit i, the logic opcodes give result[i] = G[{A[i],B[i]}], with A[i] as the high select bit. The G codes are 1000 for opcode 1000 (AND), 1110 for 1001 (OR), 0110 for 1010 (XOR) and 0011 for 1011 (NOT A).
- R7: carry_out is 0 for every logic opcode.
- R8: Unused opcodes (0101, 0111, 1100 to 1111) give result 0x00 and carry_out 0.
- R9: carry_in has no effect on either output for any opcode other than 0001 and 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | External carry, or not-borrow for the subtract form |
| op_code | input | 4 | Operation selection |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Adder bit-8 carry; 0 for logic and unused codes |

## Verification
Every opcode is swept with operands drawn from the corner set 0x00, 0x01, 0x7F, 0x80 and 0xFF, with both carry values, and then with random operands. The corner pairs separate the carry and borrow edges: A = B, A = 0 on decrement and 0xFF on increment. Random operands exercise all four select combinations of each per-bit logic mux. Each opcode that ignores the carry is applied twice with the same operands and opposite carry values, and the two outputs must match. This separates a leak of the external carry from a correct forced carry-in.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [1:0] {
        BSRC_PASS  = 2'd0,
        BSRC_INV   = 2'd1,
        BSRC_CONST = 2'd2
    } bsrc_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_EXT  = 2'd2
    } cin_e;

    typedef struct packed {
        logic       valid;
        logic       take_logic;
        bsrc_e      bsrc;
        logic       const_dec;
        cin_e       cin_mode;
        logic [3:0] gcode;
    } alu_ctl_t;

    localparam logic [3:0] G_AND  = 4'b1000;
    localparam logic [3:0] G_OR   = 4'b1110;
    localparam logic [3:0] G_XOR  = 4'b0110;
    localparam logic [3:0] G_NOTA = 4'b0011;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctl_t   ctl
);
    always_comb begin
        ctl            = '0;
        ctl.bsrc       = BSRC_PASS;
        ctl.cin_mode   = CIN_ZERO;
        ctl.take_logic = op_code[3];
        ctl.const_dec  = op_code[1];
        unique case (op_code[1:0])
            2'b00:   ctl.gcode = G_AND;
            2'b01:   ctl.gcode = G_OR;
            2'b10:   ctl.gcode = G_XOR;
            default: ctl.gcode = G_NOTA;
        endcase
        if (op_code[3]) begin
            ctl.valid = ~op_code[2];
        end else begin
            ctl.valid = ~(op_code[2] & op_code[0]);
            if (op_code[2])
                ctl.bsrc = BSRC_CONST;
            else if (op_code[1])
                ctl.bsrc = BSRC_INV;
            else
                ctl.bsrc = BSRC_PASS;
            if (op_code[0])
                ctl.cin_mode = CIN_EXT;
            else if (ctl.bsrc == BSRC_INV)
                ctl.cin_mode = CIN_ONE;
            else
                ctl.cin_mode = CIN_ZERO;
        end
    end
endmodule

// File: rtl/alu8_ripple.sv
module alu8_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;
    assign c[0] = ci;
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            assign s[i]   = x[i] ^ y[i] ^ c[i];
            assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
        end
    endgenerate
    assign co = c[W];
endmodule

// File: rtl/alu8_truth_mux.sv
module alu8_truth_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [3:0]   g,
    output logic [W-1:0] z
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_comb begin
                unique case ({x[i], y[i]})
                    2'b00:   z[i] = g[0];
                    2'b01:   z[i] = g[1];
                    2'b10:   z[i] = g[2];
                    default: z[i] = g[3];
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/alu8_mux_core.sv
module alu8_mux_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_in,
    input  logic [3:0]   op_code,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam logic [W-1:0] K_INC = W'(1);
    localparam logic [W-1:0] K_DEC = '1;

    alu_ctl_t      ctl;
    logic [W-1:0]  y_sel;
    logic          c_sel;
    logic [W-1:0]  sum;
    logic          sum_co;
    logic [W-1:0]  lgc;

    alu8_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    always_comb begin
        unique case (ctl.bsrc)
            BSRC_INV:   y_sel = ~opnd_b;
            BSRC_CONST: y_sel = ctl.const_dec ? K_DEC : K_INC;
            default:    y_sel = opnd_b;
        endcase
    end

    always_comb begin
        unique case (ctl.cin_mode)
            CIN_ONE: c_sel = 1'b1;
            CIN_EXT: c_sel = carry_in;
            default: c_sel = 1'b0;
        endcase
    end

    alu8_ripple #(.W(W)) u_add (
        .x  (opnd_a),
        .y  (y_sel),
        .ci (c_sel),
        .s  (sum),
        .co (sum_co)
    );

    alu8_truth_mux #(.W(W)) u_lgc (
        .x (opnd_a),
        .y (opnd_b),
        .g (ctl.gcode),
        .z (lgc)
    );

    always_comb begin
        if (!ctl.valid) begin
            result    = '0;
            carry_out = 1'b0;
        end else if (ctl.take_logic) begin
            result    = lgc;
            carry_out = 1'b0;
        end else begin
            result    = sum;
            carry_out = sum_co;
        end
    end
endmodule

// File: rtl/alu8_mux_core_chk.sv
module alu8_mux_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         carry_in,
    input logic [3:0]   op_code,
    input logic [W-1:0] result,
    input logic         carry_out
);
    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, carry_in, op_code, result, carry_out});

    always_comb begin
        if (known) begin
            // R7
            logic_cout_chk: assert (!(op_code[3] && carry_out));
            // R8
            unused_zero_chk: assert (!((op_code == 4'b0101 || op_code == 4'b0111 || op_code[3:2] == 2'b11)
                                       && (result != '0 || carry_out)));
            // R4
            inc_value_chk: assert (op_code != 4'b0100 || {carry_out, result} == ({1'b0, opnd_a} + (W+1)'(1)));
            // R5
            dec_value_chk: assert (op_code != 4'b0110 || (result == opnd_a - W'(1) && carry_out == (opnd_a != '0)));
            // R1
            add_value_chk: assert (op_code != 4'b0000 || {carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
            // R6
            nota_value_chk: assert (op_code != 4'b1011 || result == ~opnd_a);
        end
    end
endmodule

bind alu8_mux_core alu8_mux_core_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .op_code   (op_code),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/alu8_mux_core_tb_top.sv
module alu8_mux_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       ci = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] res;
    logic       co;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_mux_core dut_i (
        .opnd_a    (a),
        .opnd_b    (b),
        .carry_in  (ci),
        .op_code   (op),
        .result    (res),
        .carry_out (co)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'b0000, 4'b0001: return "R1";
            4'b0010:          return "R2";
            4'b0011:          return "R3";
            4'b0100:          return "R4";
            4'b0110:          return "R5";
            4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R6+R7";
            default:          return "R8";
        endcase
    endfunction

    function automatic int ref_model(input int ia, input int ib, input int ic, input int iop);
        int s;
        case (iop)
            0:  s = ia + ib;
            1:  s = ia + ib + ic;
            2:  s = ia + (255 - ib) + 1;
            3:  s = ia + (255 - ib) + ic;
            4:  s = ia + 1;
            6:  s = ia + 255;
            8:  s = ia & ib;
            9:  s = ia | ib;
            10: s = ia ^ ib;
            11: s = (~ia) & 255;
            default: s = 0;
        endcase
        return s;
    endfunction

    task automatic apply(input int ia, input int ib, input int ic, input int iop, output int got);
        @(posedge clk);
        #1;
        a = ia[7:0]; b = ib[7:0]; ci = ic[0]; op = iop[3:0];
        @(negedge clk);
        got = {23'd0, co, res};
    endtask

    task automatic check(input int ia, input int ib, input int ic, input int iop);
        int got, exp;
        apply(ia, ib, ic, iop, got);
        exp = ref_model(ia, ib, ic, iop);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s op=%b a=%h b=%h cin=%0d actual=%h expected=%h",
                     tag_of(iop[3:0]), iop[3:0], ia[7:0], ib[7:0], ic, got[8:0], exp[8:0]);
        end
    endtask

    initial begin : watchdog
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int corners [5] = '{0, 1, 127, 128, 255};
        int g0, g1;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: add of zeros gives zero (R1)
        check(0, 0, 0, 0);
        // Corner sweep over all opcodes (R1..R8)
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int c = 0; c < 2; c++)
                        check(corners[i], corners[j], c, o);
        // Random operands, all opcodes (R1..R8)
        for (int o = 0; o < 16; o++)
            for (int k = 0; k < 150; k++)
                check(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                      int'($urandom_range(0, 1)), o);
        // R9: carry input ignored except for opcodes 0001 and 0011
        for (int o = 0; o < 16; o++) begin
            if (o == 1 || o == 3) continue;
            for (int k = 0; k < 20; k++) begin
                int ra = int'($urandom_range(0, 255));
                int rb = int'($urandom_range(0, 255));
                apply(ra, rb, 0, o, g0);
                apply(ra, rb, 1, o, g1);
                n_cmp++;
                if (g0 != g1) begin
                    n_bad++;
                    $display("FAIL R9 op=%b a=%h b=%h actual(cin=1)=%h expected(cin=0)=%h",
                             o[3:0], ra[7:0], rb[7:0], g1[8:0], g0[8:0]);
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule